// File: doc/BRIEF.md
# Dataflow Channel Stall Monitor

This block watches one or more handshaked FIFO channels in a dataflow network without touching them. For each channel it observes the writer's write request, the channel's full indication, the reader's read request and the channel's empty indication. From these it tracks the current fill level and the peak fill level since reset. It also counts the cycles a writer spends stopped by a full channel and, separately, the cycles a reader spends stopped by an empty channel. Sizing a channel then comes down to reading its peak and trimming its depth to that value.

A single shared stall timer runs while no channel accepts a push or a pop and at least one party is blocked. When the timer reaches a programmable limit, the block classifies the stall. If at least one writer is blocked on a full channel, the stall is a sizing deadlock. The block raises a sticky flag and records which channels were full at that moment. If only readers are blocked, the stall is a design fault rather than a sizing problem, and the block raises a separate sticky flag. All counters and flags are read through an address/data read port.

Top module: `chan_stall_monitor`

## Requirements
- R1: The occupancy of channel i rises by one on a clock edge where `ch_wr_en[i]` is 1 and `ch_full[i]` is 0. It falls by one on an edge where `ch_rd_en[i]` is 1 and `ch_empty[i]` is 0. It stays unchanged when both or neither happen.
- R2: The peak occupancy of each channel updates on the same edge as the occupancy that exceeds it. It never decreases until reset.
- R3: The global status word at select 2 holds `ch_full` (bit i for channel i). The word at select 3 holds `ch_empty`. Both reflect the current inputs.
- R4: The write-stall counter of channel i counts the edges with `ch_wr_en[i]` and `ch_full[i]` both 1. It saturates at 2^CNT_W-1.
- R5: The read-stall counter of channel i counts the edges with `ch_rd_en[i]` and `ch_empty[i]` both 1. It is kept apart from the write-stall counter and also saturates.
- R6: A stall edge is an edge with no accepted push or pop on any channel and at least one blocked writer or reader. The stall is declared at the end of the `stall_limit`-th consecutive stall edge. Any accepted push or pop restarts the count.
- R7: `deadlock` is raised on declaration only if at least one writer is blocked on a full channel. It then stays 1 until reset.
- R8: The full mask (global select 1) captures `ch_full` on the edge that raises `deadlock`. It is held unchanged afterwards.
- R9: `design_err` is raised on declaration when no writer is blocked (only readers). It is sticky, and `deadlock` stays 0 for that stall.
- R10: Read address = {channel, select[1:0]}. For a channel, select 0 = occupancy, 1 = peak, 2 = write stalls, 3 = read stalls. Channel index NUM_CH selects the global words: 0 = flags (bit0 deadlock, bit1 design error), 1 = full mask, 2 = full now, 3 = empty now. Higher indices read 0. With READ_LATENCY=1, `rd_data` shows the word for the address applied one edge earlier.
- R11: After reset all counters, peaks, flags and the mask are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_wr_en | input | NUM_CH | Writer requests a push, per channel |
| ch_full | input | NUM_CH | Channel full indication, per channel |
| ch_rd_en | input | NUM_CH | Reader requests a pop, per channel |
| ch_empty | input | NUM_CH | Channel empty indication, per channel |
| stall_limit | input | TMO_W | Consecutive stall edges before a stall is declared |
| rd_addr | input | CH_AW+2 | Register read address {channel, select} |
| rd_data | output | DATA_W | Register read data |
| deadlock | output | 1 | Sticky sizing-deadlock flag |
| design_err | output | 1 | Sticky stall-without-blocked-writer flag |

## Verification
The bench builds the monitor with two channels, a 4-bit occupancy, 6-bit stall counters, a 5-bit stall timer, 16-bit read data and the registered read path. With 6-bit stall counters, a held block of 70 cycles reaches counter saturation at 63. With two channels, a whole channel index (read addresses 12 to 15) lies beyond the global words, so the zero-read rule can be checked. A producer/consumer model, where the producer fills channel A before channel B while the consumer alternates starting on B, drives channel depths 3, 5, 6 and 8 against a stall limit of 8. Depths below six must deadlock with A full. Depths of six or more must drain and leave A's peak at six.

// File: rtl/cs_pkg.sv
package cs_pkg;

   typedef enum logic [1:0] {
      CSEL_OCC  = 2'd0,
      CSEL_PEAK = 2'd1,
      CSEL_WBLK = 2'd2,
      CSEL_RBLK = 2'd3
   } chan_sel_e;

   typedef enum logic [1:0] {
      GSEL_FLAGS = 2'd0,
      GSEL_MASK  = 2'd1,
      GSEL_FULL  = 2'd2,
      GSEL_EMPTY = 2'd3
   } glob_sel_e;

   localparam int FLAG_DEADLOCK_BIT = 0;
   localparam int FLAG_DESIGN_BIT   = 1;
   localparam int FLAG_W            = 2;

endpackage

// File: rtl/cs_sat_counter.sv
module cs_sat_counter #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             bump,
   output logic [WIDTH-1:0] count
);

   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clear) begin
         count <= '0;
      end else if (bump && (count != TOP)) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/cs_chan_track.sv
module cs_chan_track #(
   parameter int OCC_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             full,
   input  logic             rd_en,
   input  logic             empty,
   output logic             push_ok,
   output logic             pop_ok,
   output logic             wr_blk,
   output logic             rd_blk,
   output logic [OCC_W-1:0] occ,
   output logic [OCC_W-1:0] peak,
   output logic [CNT_W-1:0] wr_stall,
   output logic [CNT_W-1:0] rd_stall
);

   localparam logic [OCC_W-1:0] OCC_TOP = {OCC_W{1'b1}};

   logic [OCC_W-1:0] occ_nxt;

   assign push_ok = wr_en & ~full;
   assign pop_ok  = rd_en & ~empty;
   assign wr_blk  = wr_en & full;
   assign rd_blk  = rd_en & empty;

   always_comb begin
      occ_nxt = occ;
      if (push_ok && !pop_ok && (occ != OCC_TOP)) begin
         occ_nxt = occ + 1'b1;
      end else if (pop_ok && !push_ok && (occ != '0)) begin
         occ_nxt = occ - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ  <= '0;
         peak <= '0;
      end else begin
         occ <= occ_nxt;
         if (occ_nxt > peak) begin
            peak <= occ_nxt;
         end
      end
   end

   cs_sat_counter #(.WIDTH(CNT_W)) u_wr_stall (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (1'b0),
      .bump  (wr_blk),
      .count (wr_stall)
   );

   cs_sat_counter #(.WIDTH(CNT_W)) u_rd_stall (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (1'b0),
      .bump  (rd_blk),
      .count (rd_stall)
   );

endmodule

// File: rtl/cs_stall_detect.sv
module cs_stall_detect #(
   parameter int NUM_CH = 4,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              progress,
   input  logic [NUM_CH-1:0] wr_blk,
   input  logic [NUM_CH-1:0] rd_blk,
   input  logic [NUM_CH-1:0] full_now,
   input  logic [TMO_W-1:0]  limit,
   output logic              deadlock,
   output logic              design_err,
   output logic [NUM_CH-1:0] full_mask
);

   logic             any_wr;
   logic             any_rd;
   logic             stalled;
   logic             expire;
   logic [TMO_W-1:0] quiet;
   logic [TMO_W:0]   quiet_ext;

   assign any_wr    = |wr_blk;
   assign any_rd    = |rd_blk;
   assign stalled   = !progress && (any_wr || any_rd);
   assign quiet_ext = {1'b0, quiet} + 1'b1;
   assign expire    = stalled && (quiet_ext >= {1'b0, limit});

   cs_sat_counter #(.WIDTH(TMO_W)) u_quiet (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (!stalled),
      .bump  (stalled),
      .count (quiet)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         deadlock   <= 1'b0;
         design_err <= 1'b0;
         full_mask  <= '0;
      end else if (expire) begin
         if (any_wr) begin
            if (!deadlock) begin
               deadlock  <= 1'b1;
               full_mask <= full_now;
            end
         end else begin
            design_err <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/cs_read_mux.sv
module cs_read_mux
   import cs_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int OCC_W  = 8,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 32,
   parameter int CH_AW  = 3
) (
   input  logic [CH_AW+1:0]              addr,
   input  logic [NUM_CH-1:0][OCC_W-1:0]  occ_v,
   input  logic [NUM_CH-1:0][OCC_W-1:0]  peak_v,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  wst_v,
   input  logic [NUM_CH-1:0][CNT_W-1:0]  rst_v,
   input  logic [FLAG_W-1:0]             flags,
   input  logic [NUM_CH-1:0]             full_mask,
   input  logic [NUM_CH-1:0]             full_now,
   input  logic [NUM_CH-1:0]             empty_now,
   output logic [DATA_W-1:0]             data
);

   logic [CH_AW-1:0] ch_idx;
   logic [1:0]       sel;

   assign ch_idx = addr[CH_AW+1:2];
   assign sel    = addr[1:0];

   always_comb begin
      data = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_idx == CH_AW'(i)) begin
            case (chan_sel_e'(sel))
               CSEL_OCC:  data = DATA_W'(occ_v[i]);
               CSEL_PEAK: data = DATA_W'(peak_v[i]);
               CSEL_WBLK: data = DATA_W'(wst_v[i]);
               CSEL_RBLK: data = DATA_W'(rst_v[i]);
               default:   data = '0;
            endcase
         end
      end
      if (ch_idx == CH_AW'(NUM_CH)) begin
         case (glob_sel_e'(sel))
            GSEL_FLAGS: data = DATA_W'(flags);
            GSEL_MASK:  data = DATA_W'(full_mask);
            GSEL_FULL:  data = DATA_W'(full_now);
            GSEL_EMPTY: data = DATA_W'(empty_now);
            default:    data = '0;
         endcase
      end
   end

endmodule

// File: rtl/chan_stall_monitor.sv
module chan_stall_monitor
   import cs_pkg::*;
#(
   parameter int NUM_CH       = 4,
   parameter int OCC_W        = 8,
   parameter int CNT_W        = 16,
   parameter int TMO_W        = 16,
   parameter int DATA_W       = 32,
   parameter int READ_LATENCY = 1,
   localparam int CH_AW       = $clog2(NUM_CH + 1),
   localparam int ADDR_W      = CH_AW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_wr_en,
   input  logic [NUM_CH-1:0] ch_full,
   input  logic [NUM_CH-1:0] ch_rd_en,
   input  logic [NUM_CH-1:0] ch_empty,
   input  logic [TMO_W-1:0]  stall_limit,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              deadlock,
   output logic              design_err
);

   if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_nch
      $error("chan_stall_monitor: NUM_CH must lie in 1..DATA_W");
   end
   if (OCC_W < 1 || OCC_W > DATA_W) begin : g_bad_occ
      $error("chan_stall_monitor: OCC_W must lie in 1..DATA_W");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("chan_stall_monitor: CNT_W must lie in 1..DATA_W");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("chan_stall_monitor: TMO_W must be at least 1");
   end
   if (DATA_W < FLAG_W) begin : g_bad_data
      $error("chan_stall_monitor: DATA_W too narrow for the flag word");
   end
   if (READ_LATENCY != 0 && READ_LATENCY != 1) begin : g_bad_lat
      $error("chan_stall_monitor: READ_LATENCY must be 0 or 1");
   end

   logic [NUM_CH-1:0]             push_ok_v;
   logic [NUM_CH-1:0]             pop_ok_v;
   logic [NUM_CH-1:0]             wr_blk_v;
   logic [NUM_CH-1:0]             rd_blk_v;
   logic [NUM_CH-1:0][OCC_W-1:0]  occ_v;
   logic [NUM_CH-1:0][OCC_W-1:0]  peak_v;
   logic [NUM_CH-1:0][CNT_W-1:0]  wst_v;
   logic [NUM_CH-1:0][CNT_W-1:0]  rst_v;
   logic [NUM_CH-1:0]             full_mask;
   logic                          progress;
   logic [FLAG_W-1:0]             flags;
   logic [DATA_W-1:0]             mux_data;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      cs_chan_track #(
         .OCC_W (OCC_W),
         .CNT_W (CNT_W)
      ) u_track (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (ch_wr_en[g]),
         .full     (ch_full[g]),
         .rd_en    (ch_rd_en[g]),
         .empty    (ch_empty[g]),
         .push_ok  (push_ok_v[g]),
         .pop_ok   (pop_ok_v[g]),
         .wr_blk   (wr_blk_v[g]),
         .rd_blk   (rd_blk_v[g]),
         .occ      (occ_v[g]),
         .peak     (peak_v[g]),
         .wr_stall (wst_v[g]),
         .rd_stall (rst_v[g])
      );
   end

   assign progress = (|push_ok_v) | (|pop_ok_v);

   cs_stall_detect #(
      .NUM_CH (NUM_CH),
      .TMO_W  (TMO_W)
   ) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .progress   (progress),
      .wr_blk     (wr_blk_v),
      .rd_blk     (rd_blk_v),
      .full_now   (ch_full),
      .limit      (stall_limit),
      .deadlock   (deadlock),
      .design_err (design_err),
      .full_mask  (full_mask)
   );

   always_comb begin
      flags                    = '0;
      flags[FLAG_DEADLOCK_BIT] = deadlock;
      flags[FLAG_DESIGN_BIT]   = design_err;
   end

   cs_read_mux #(
      .NUM_CH (NUM_CH),
      .OCC_W  (OCC_W),
      .CNT_W  (CNT_W),
      .DATA_W (DATA_W),
      .CH_AW  (CH_AW)
   ) u_mux (
      .addr      (rd_addr),
      .occ_v     (occ_v),
      .peak_v    (peak_v),
      .wst_v     (wst_v),
      .rst_v     (rst_v),
      .flags     (flags),
      .full_mask (full_mask),
      .full_now  (ch_full),
      .empty_now (ch_empty),
      .data      (mux_data)
   );

   if (READ_LATENCY == 1) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data <= '0;
         end else begin
            rd_data <= mux_data;
         end
      end
   end else begin : g_rd_comb
      assign rd_data = mux_data;
   end

endmodule

// File: rtl/cs_monitor_chk.sv
module cs_monitor_chk #(
   parameter int NUM_CH = 4,
   parameter int OCC_W  = 8,
   parameter int CNT_W  = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_CH-1:0]             ch_wr_en,
   input logic [NUM_CH-1:0]             ch_full,
   input logic [NUM_CH-1:0]             ch_rd_en,
   input logic [NUM_CH-1:0]             ch_empty,
   input logic                          deadlock,
   input logic                          design_err,
   input logic [NUM_CH-1:0]             full_mask,
   input logic [NUM_CH-1:0][OCC_W-1:0]  occ_v,
   input logic [NUM_CH-1:0][OCC_W-1:0]  peak_v,
   input logic [NUM_CH-1:0][CNT_W-1:0]  wst_v,
   input logic [NUM_CH-1:0][CNT_W-1:0]  rst_v
);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_a
      AST_OCC_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (occ_v[g] == $past(occ_v[g])) || (occ_v[g] == $past(occ_v[g]) + 1'b1) || (occ_v[g] + 1'b1 == $past(occ_v[g]))); // R1
      AST_PEAK_COVERS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
         peak_v[g] >= occ_v[g]); // R2
      AST_PEAK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
         peak_v[g] >= $past(peak_v[g])); // R2
      AST_WSTALL_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
         (wst_v[g] == {CNT_W{1'b1}}) |=> (wst_v[g] == {CNT_W{1'b1}})); // R4
      AST_RSTALL_HOLDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_v[g] == {CNT_W{1'b1}}) |=> (rst_v[g] == {CNT_W{1'b1}})); // R5
   end

   AST_DEADLOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> deadlock); // R7
   AST_DEADLOCK_NEEDS_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deadlock) |-> $past(|(ch_wr_en & ch_full))); // R7
   AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> $stable(full_mask)); // R8
   AST_DESIGN_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      design_err |=> design_err); // R9
   AST_DESIGN_ERR_NO_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(design_err) |-> (!$past(|(ch_wr_en & ch_full)) && $past(|(ch_rd_en & ch_empty)))); // R9

endmodule

bind chan_stall_monitor cs_monitor_chk #(
   .NUM_CH (NUM_CH),
   .OCC_W  (OCC_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ch_wr_en   (ch_wr_en),
   .ch_full    (ch_full),
   .ch_rd_en   (ch_rd_en),
   .ch_empty   (ch_empty),
   .deadlock   (deadlock),
   .design_err (design_err),
   .full_mask  (full_mask),
   .occ_v      (occ_v),
   .peak_v     (peak_v),
   .wst_v      (wst_v),
   .rst_v      (rst_v)
);

// File: tb/test_chan_stall_monitor.sv
`timescale 1ns/1ps
module test_chan_stall_monitor;

   localparam int NUM_CH = 2;
   localparam int OCC_W  = 4;
   localparam int CNT_W  = 6;
   localparam int TMO_W  = 5;
   localparam int DATA_W = 16;
   localparam int ADDR_W = $clog2(NUM_CH + 1) + 2;
   localparam int BURST  = 6;
   localparam int LIMIT  = 8;

   // depth, deadlock, mask, peakA, peakB, occA, occB
   localparam int ROWS = 4;
   localparam int TBL [ROWS][7] = '{
      '{3, 1, 1, 3, 0, 3, 0},
      '{5, 1, 1, 5, 0, 5, 0},
      '{6, 0, 0, 6, 3, 0, 0},
      '{8, 0, 0, 6, 3, 0, 0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] ch_wr_en = '0;
   logic [NUM_CH-1:0] ch_full = '0;
   logic [NUM_CH-1:0] ch_rd_en = '0;
   logic [NUM_CH-1:0] ch_empty = '1;
   logic [TMO_W-1:0]  stall_limit = TMO_W'(LIMIT);
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              deadlock;
   logic              design_err;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   chan_stall_monitor #(
      .NUM_CH       (NUM_CH),
      .OCC_W        (OCC_W),
      .CNT_W        (CNT_W),
      .TMO_W        (TMO_W),
      .DATA_W       (DATA_W),
      .READ_LATENCY (1)
   ) i_chan_stall_monitor (
      .clk         (clk),
      .rst_n       (rst_n),
      .ch_wr_en    (ch_wr_en),
      .ch_full     (ch_full),
      .ch_rd_en    (ch_rd_en),
      .ch_empty    (ch_empty),
      .stall_limit (stall_limit),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .deadlock    (deadlock),
      .design_err  (design_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      ch_wr_en = '0;
      ch_full  = '0;
      ch_rd_en = '0;
      ch_empty = '1;
      rd_addr  = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic read_reg(input int addr, output int val);
      @(negedge clk);
      rd_addr = ADDR_W'(addr);
      @(negedge clk);
      val = int'(rd_data);
   endtask

   // producer: BURST items to A (ch0), then BURST to B (ch1)
   // consumer: alternates B, A, B, A ...
   task automatic run_flow(input int depth, input int cycles);
      int ca = 0;
      int cb = 0;
      int pc = 0;
      int cc = 0;
      for (int t = 0; t < cycles; t++) begin
         ch_full[0]  = (ca == depth);
         ch_full[1]  = (cb == depth);
         ch_empty[0] = (ca == 0);
         ch_empty[1] = (cb == 0);
         if (pc < 2*BURST) ch_wr_en = (pc < BURST) ? 2'b01 : 2'b10;
         else              ch_wr_en = 2'b00;
         if (cc < 2*BURST) ch_rd_en = (cc % 2 == 0) ? 2'b10 : 2'b01;
         else              ch_rd_en = 2'b00;
         @(posedge clk);
         begin
            logic pa, pb, ra, rb;
            pa = ch_wr_en[0] & ~ch_full[0];
            pb = ch_wr_en[1] & ~ch_full[1];
            ra = ch_rd_en[0] & ~ch_empty[0];
            rb = ch_rd_en[1] & ~ch_empty[1];
            ca = ca + int'(pa) - int'(ra);
            cb = cb + int'(pb) - int'(rb);
            pc = pc + int'(pa | pb);
            cc = cc + int'(ra | rb);
         end
         @(negedge clk);
      end
      ch_wr_en = '0;
      ch_rd_en = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v;
      stall_limit = TMO_W'(LIMIT);

      // ---------- table-driven producer/consumer scenarios ----------
      for (int r = 0; r < ROWS; r++) begin
         do_reset();
         run_flow(TBL[r][0], 40);
         chk($sformatf("R7 row%0d deadlock", r), int'(deadlock), TBL[r][1]);
         chk($sformatf("R9 row%0d design_err", r), int'(design_err), 0);
         read_reg(9, v); chk($sformatf("R8 row%0d mask", r), v, TBL[r][2]);
         read_reg(1, v); chk($sformatf("R2 row%0d peakA", r), v, TBL[r][3]);
         read_reg(5, v); chk($sformatf("R2 row%0d peakB", r), v, TBL[r][4]);
         read_reg(0, v); chk($sformatf("R1 row%0d occA", r), v, TBL[r][5]);
         read_reg(4, v); chk($sformatf("R1 row%0d occB", r), v, TBL[r][6]);
      end

      // ---------- reset state ----------
      do_reset();
      chk("R11 deadlock after reset", int'(deadlock), 0);
      chk("R11 design_err after reset", int'(design_err), 0);
      for (int a = 0; a < 11; a++) begin
         read_reg(a, v);
         chk($sformatf("R11 addr%0d after reset", a), v, 0);
      end
      read_reg(11, v); chk("R3 empty-now after reset", v, 3);
      read_reg(13, v); chk("R10 unmapped addr reads 0", v, 0);

      // ---------- occupancy, peak, status words, read latency ----------
      do_reset();
      ch_wr_en = 2'b01; ch_full = 2'b00;
      repeat (3) @(negedge clk);
      ch_wr_en = 2'b00; ch_rd_en = 2'b01; ch_empty = 2'b00;
      @(negedge clk);
      ch_rd_en = 2'b00;
      read_reg(0, v); chk("R1 occ after 3 push 1 pop", v, 2);
      rd_addr = ADDR_W'(1);
      #1 chk("R10 data before edge keeps old word", int'(rd_data), 2);
      @(negedge clk);
      chk("R2 peak after 3 push 1 pop", int'(rd_data), 3);
      ch_full = 2'b10; ch_empty = 2'b01;
      read_reg(10, v); chk("R3 full-now word", v, 2);
      read_reg(11, v); chk("R3 empty-now word", v, 1);

      // ---------- threshold, saturation, sticky, mask ----------
      do_reset();
      ch_wr_en = 2'b01; ch_full = 2'b01;
      repeat (7) @(negedge clk);
      chk("R6 no deadlock after limit-1 stall edges", int'(deadlock), 0);
      @(negedge clk);
      chk("R6 deadlock at limit-th stall edge", int'(deadlock), 1);
      repeat (62) @(negedge clk);
      ch_wr_en = 2'b00;
      read_reg(2, v); chk("R4 write-stall saturates", v, 63);
      read_reg(3, v); chk("R5 read-stall kept separate", v, 0);
      read_reg(9, v); chk("R8 mask at detection", v, 1);
      ch_full = 2'b10;
      @(negedge clk);
      ch_full = 2'b00; ch_wr_en = 2'b01;
      repeat (2) @(negedge clk);
      ch_wr_en = 2'b00;
      chk("R7 deadlock sticky after progress", int'(deadlock), 1);
      read_reg(9, v); chk("R8 mask held after full changes", v, 1);
      read_reg(8, v); chk("R10 flags word deadlock bit", v, 1);

      // ---------- progress restarts the stall count ----------
      do_reset();
      ch_wr_en = 2'b01; ch_full = 2'b01;
      repeat (5) @(negedge clk);
      ch_wr_en = 2'b11;
      @(negedge clk);
      ch_wr_en = 2'b01;
      repeat (7) @(negedge clk);
      chk("R6 count restarted by progress", int'(deadlock), 0);
      @(negedge clk);
      chk("R6 deadlock after fresh limit", int'(deadlock), 1);
      ch_wr_en = 2'b00;

      // ---------- reader-only stall ----------
      do_reset();
      ch_rd_en = 2'b10;
      repeat (10) @(negedge clk);
      ch_rd_en = 2'b00;
      chk("R9 design_err on reader-only stall", int'(design_err), 1);
      chk("R9 deadlock stays low", int'(deadlock), 0);
      read_reg(7, v); chk("R5 read-stall count ch1", v, 10);
      read_reg(6, v); chk("R4 write-stall count ch1", v, 0);
      read_reg(8, v); chk("R10 flags word design bit", v, 2);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule